// File: doc/BRIEF.md
# DMA Global Control and Status Register

This block is the shared control point of a multi-channel DMA controller. It holds a master enable and two sticky error flags, one raised by the address checker when a transfer uses an illegal address and one raised by the non-maskable interrupt line. From these three bits and each channel's own enable and transfer-end inputs, it produces a per-channel start qualifier. A channel may only begin moving data while its qualifier is high.

Software reaches the register over a minimal strobe bus. Read data is always present. A read strobe marks the moment software has observed the value, and a write strobe loads new contents. An error flag can be cleared only by a deliberate two-step sequence: software must first read the flag as 1, then write 0 to it. This stops a stray write from hiding an error. Dropping the master enable sends a one-cycle abort to every channel that is busy at that moment. Entry into standby wipes the whole register.

Top module: `dgc_top`

## Requirements
- R1: After reset, all three register bits and every output are 0. The register bit layout is fixed: bit 2 is the address-error flag, bit 1 is the NMI flag and bit 0 is the master enable. `rd_data` always shows the current register value.
- R2: A write (`wr_en`=1) loads `wr_data[0]` into the master enable, and the new value appears on the next cycle.
- R3: A pulse on `addr_err_evt` sets bit 2 on the next cycle, and a pulse on `nmi_evt` sets bit 1 on the next cycle. Both flags set regardless of whether the master enable is on.
- R4: The flags are sticky. Writing 1 to a flag bit never sets it. Writing 0 to a flag that has not been read as 1 since the last write leaves it at 1.
- R5: A read (`rd_en`=1) that returns a flag as 1 arms that flag. A later write with 0 in that bit clears the flag on the next cycle. Every write consumes the arming of both flags.
- R6: If a set event and an armed clearing write occur in the same cycle, the flag stays 1.
- R7: `ch_go[i]` is combinationally 1 exactly when `ch_en[i]`=1, the master enable is 1, `ch_te[i]`=0, and both flags are 0.
- R8: When the master enable goes from 1 to 0, by a write or by standby, `ch_abort` carries the `ch_busy` value of that cycle for exactly one cycle. The pulse appears on the next cycle. Otherwise `ch_abort` is 0.
- R9: `standby`=1 clears all three bits and both armings on the next cycle. It takes priority over set events and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby entry; clears the register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 3 | Write data |
| rd_data | output | 3 | Register value {addr-error, nmi, master enable} |
| addr_err_evt | input | 1 | Address error event |
| nmi_evt | input | 1 | NMI event |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_te | input | NUM_CH | Per-channel transfer-end flag |
| ch_busy | input | NUM_CH | Per-channel transfer in progress |
| ch_go | output | NUM_CH | Per-channel start qualifier |
| ch_abort | output | NUM_CH | Per-channel abort pulse |

## Verification
The bench covers these corner cases:
- **Write without a prior read.** A write of 0 to a flag that was never read as 1 must leave the flag set. A design that skipped the arming step would lose errors to a blind write.
- **Arming across standby.** An arming taken before standby must not let a later write clear a flag raised after standby. A design that kept the arm would clear that new error.
- **Set event during a clearing write.** When a set event meets an armed clearing write in the same cycle, the flag must stay 1. A design that let the clear win would drop an NMI.
- **Abort pulse.** The pulse must last one cycle and reach only the busy channels, whether the enable falls by a write or by standby. A design that got this wrong would stretch the pulse, abort idle channels, or miss the standby path.
- **Start qualifier sweep.** The qualifier is swept over every enable and transfer-end combination under each gating condition.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  localparam int REG_W   = 3;
  localparam int BIT_ME  = 0;
  localparam int BIT_NMI = 1;
  localparam int BIT_AE  = 2;

  // next state of one sticky flag
  function automatic logic flag_next(input logic cur, input logic set_evt,
                                     input logic clr_ok, input logic sb);
    if (sb)           return 1'b0;
    else if (set_evt) return 1'b1;
    else if (clr_ok)  return 1'b0;
    else              return cur;
  endfunction

  // next state of one arm bit
  function automatic logic arm_next(input logic cur, input logic rd_hit,
                                    input logic wr, input logic sb);
    if (sb)      return 1'b0;
    else if (wr) return rd_hit;
    else         return cur | rd_hit;
  endfunction

  // combined global permission for every channel
  function automatic logic global_ok(input logic me, input logic ae, input logic nmi);
    return me & ~ae & ~nmi;
  endfunction
endpackage

// File: rtl/dgc_flag.sv
module dgc_flag
  import dgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic set_evt,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag_q,
  output logic armed_q,
  output logic clr_ok
);
  logic rd_hit;

  assign rd_hit = rd_en & flag_q;
  assign clr_ok = wr_en & ~wr_bit & armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_next(flag_q, set_evt, clr_ok, standby);
      armed_q <= arm_next(armed_q, rd_hit, wr_en, standby);
    end
  end
endmodule

// File: rtl/dgc_master.sv
module dgc_master #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic [NUM_CH-1:0] ch_busy,
  output logic              me_q,
  output logic              me_fall,
  output logic [NUM_CH-1:0] abort_q
);
  logic me_d;

  always_comb begin
    if (standby)    me_d = 1'b0;
    else if (wr_en) me_d = wr_bit;
    else            me_d = me_q;
  end

  assign me_fall = me_q & ~me_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      me_q    <= 1'b0;
      abort_q <= '0;
    end else begin
      me_q    <= me_d;
      abort_q <= me_fall ? ch_busy : '0;
    end
  end
endmodule

// File: rtl/dgc_gate.sv
module dgc_gate #(
  parameter int NUM_CH = 4
) (
  input  logic              glob_ok,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_te,
  output logic [NUM_CH-1:0] ch_go
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_go[i] = glob_ok & ch_en[i] & ~ch_te[i];
  end
endmodule

// File: rtl/dgc_top.sv
module dgc_top
  import dgc_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              addr_err_evt,
  input  logic              nmi_evt,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_te,
  input  logic [NUM_CH-1:0] ch_busy,
  output logic [NUM_CH-1:0] ch_go,
  output logic [NUM_CH-1:0] ch_abort
);
  logic ae_q, ae_armed, ae_clr;
  logic nmi_q, nmi_armed, nmi_clr;
  logic me_q, me_fall;
  logic glob_ok;

  dgc_flag u_ae (
    .clk(clk), .rst_n(rst_n), .standby(standby), .set_evt(addr_err_evt),
    .rd_en(rd_en), .wr_en(wr_en), .wr_bit(wr_data[BIT_AE]),
    .flag_q(ae_q), .armed_q(ae_armed), .clr_ok(ae_clr)
  );

  dgc_flag u_nmi (
    .clk(clk), .rst_n(rst_n), .standby(standby), .set_evt(nmi_evt),
    .rd_en(rd_en), .wr_en(wr_en), .wr_bit(wr_data[BIT_NMI]),
    .flag_q(nmi_q), .armed_q(nmi_armed), .clr_ok(nmi_clr)
  );

  dgc_master #(.NUM_CH(NUM_CH)) u_me (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
    .wr_bit(wr_data[BIT_ME]), .ch_busy(ch_busy),
    .me_q(me_q), .me_fall(me_fall), .abort_q(ch_abort)
  );

  assign glob_ok = global_ok(me_q, ae_q, nmi_q);

  dgc_gate #(.NUM_CH(NUM_CH)) u_gate (
    .glob_ok(glob_ok), .ch_en(ch_en), .ch_te(ch_te), .ch_go(ch_go)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_AE]  = ae_q;
    rd_data[BIT_NMI] = nmi_q;
    rd_data[BIT_ME]  = me_q;
  end
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              wr_en,
  input logic [2:0]        wr_data,
  input logic [2:0]        rd_data,
  input logic              addr_err_evt,
  input logic              nmi_evt,
  input logic              ae_armed,
  input logic              me_fall,
  input logic [NUM_CH-1:0] ch_go,
  input logic [NUM_CH-1:0] ch_abort
);
  a_r3_ae_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err_evt && !standby) |=> rd_data[2]);

  a_r3_nmi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt && !standby) |=> rd_data[1]);

  a_r4_blind_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] && wr_en && !ae_armed && !standby) |=> rd_data[2]);

  a_r4_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[2] && !addr_err_evt) |=> !rd_data[2]);

  a_r7_go_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_go) |-> (rd_data == 3'b001));

  a_r8_abort_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_abort) |-> (!rd_data[0] && $past(rd_data[0])));

  a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_abort) |=> (ch_abort == '0));

  a_r8_no_fall_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !me_fall |=> (ch_abort == '0));

  a_r9_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (rd_data == 3'b000));

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !standby) |=> (rd_data[0] == $past(wr_data[0])));
endmodule

bind dgc_top dgc_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .addr_err_evt(addr_err_evt),
  .nmi_evt(nmi_evt), .ae_armed(ae_armed), .me_fall(me_fall),
  .ch_go(ch_go), .ch_abort(ch_abort)
);

// File: tb/dgc_top_tb_top.sv
`timescale 1ns/1ps
module dgc_top_tb_top;
  localparam int N = 4;

  logic clk = 0, rst_n = 0, standby = 0, rd_en = 0, wr_en = 0;
  logic [2:0] wr_data = 0, rd_data;
  logic addr_err_evt = 0, nmi_evt = 0;
  logic [N-1:0] ch_en = 0, ch_te = 0, ch_busy = 0, ch_go, ch_abort;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dgc_top #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .standby(standby), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .addr_err_evt(addr_err_evt),
    .nmi_evt(nmi_evt), .ch_en(ch_en), .ch_te(ch_te), .ch_busy(ch_busy),
    .ch_go(ch_go), .ch_abort(ch_abort)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one clock with the given strobes, ending at the following negedge
  task automatic step(input bit rd, input bit wr, input logic [2:0] wd,
                      input bit aev, input bit nev, input bit sb);
    rd_en = rd; wr_en = wr; wr_data = wd;
    addr_err_evt = aev; nmi_evt = nev; standby = sb;
    @(posedge clk); @(negedge clk);
    rd_en = 0; wr_en = 0; wr_data = 0; addr_err_evt = 0; nmi_evt = 0; standby = 0;
  endtask

  task automatic idle(); step(0, 0, 3'b000, 0, 0, 0); endtask

  // expected qualifier from R7, written as a per-channel loop
  function automatic logic [N-1:0] go_exp(input logic [2:0] r, input logic [N-1:0] en,
                                          input logic [N-1:0] te);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (r == 3'b001) ? (en[i] && !te[i]) : 1'b0;
    return v;
  endfunction

  task automatic sweep(input logic [2:0] r, input string req);
    for (int e = 0; e < (1 << N); e++)
      for (int t = 0; t < (1 << N); t++) begin
        ch_en = N'(e); ch_te = N'(t); #1;
        chk(req, int'(ch_go), int'(go_exp(r, N'(e), N'(t))));
      end
    ch_en = 0; ch_te = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset rd", int'(rd_data), 0);
    chk("R1 reset abort", int'(ch_abort), 0);
    rst_n = 1; idle();
    chk("R1 after reset", int'(rd_data), 0);
    sweep(3'b000, "R7 me off");

    step(0, 1, 3'b001, 0, 0, 0);
    chk("R2 me set", int'(rd_data), 1);
    sweep(3'b001, "R7 me on");

    // R3 address error sets while enabled
    step(0, 0, 3'b000, 1, 0, 0);
    chk("R3 ae set", int'(rd_data), 3'b101);
    sweep(3'b101, "R7 ae gates");

    // R4 write of 0 without prior read, and write of 1
    step(0, 1, 3'b001, 0, 0, 0);
    chk("R4 blind write", int'(rd_data), 3'b101);
    step(0, 1, 3'b111, 0, 0, 0);
    chk("R4 write one nmi", int'(rd_data), 3'b101);

    // R5 read then write clears
    step(1, 0, 3'b000, 0, 0, 0);
    idle();
    chk("R5 read no change", int'(rd_data), 3'b101);
    step(0, 1, 3'b001, 0, 0, 0);
    chk("R5 armed clear", int'(rd_data), 3'b001);

    // R5 write consumes arm
    step(0, 0, 3'b000, 1, 0, 0);
    step(1, 0, 3'b000, 0, 0, 0);
    step(0, 1, 3'b101, 0, 0, 0);
    step(0, 1, 3'b001, 0, 0, 0);
    chk("R5 arm consumed", int'(rd_data), 3'b101);
    step(1, 0, 3'b000, 0, 0, 0);
    step(0, 1, 3'b001, 0, 0, 0);
    chk("R5 clear again", int'(rd_data), 3'b001);

    // R3 nmi, R6 set wins over clear
    step(0, 0, 3'b000, 0, 1, 0);
    chk("R3 nmi set", int'(rd_data), 3'b011);
    sweep(3'b011, "R7 nmi gates");
    step(1, 0, 3'b000, 0, 0, 0);
    step(0, 1, 3'b001, 0, 1, 0);
    chk("R6 set wins", int'(rd_data), 3'b011);
    step(1, 0, 3'b000, 0, 0, 0);
    step(0, 1, 3'b001, 0, 0, 0);
    chk("R5 nmi cleared", int'(rd_data), 3'b001);

    // R8 abort on write
    ch_busy = 4'b0101;
    step(0, 1, 3'b000, 0, 0, 0);
    chk("R8 abort write", int'(ch_abort), 4'b0101);
    chk("R2 me cleared", int'(rd_data), 0);
    idle();
    chk("R8 abort one cycle", int'(ch_abort), 0);
    step(0, 1, 3'b000, 0, 0, 0);
    chk("R8 no abort 0->0", int'(ch_abort), 0);

    // R3 nmi while idle
    step(0, 0, 3'b000, 0, 1, 0);
    chk("R3 nmi idle", int'(rd_data), 3'b010);

    // R9 standby clears, with abort from enable falling
    step(0, 1, 3'b001, 1, 0, 0);
    ch_busy = 4'b1010;
    step(1, 0, 3'b000, 0, 0, 0);
    step(0, 0, 3'b000, 0, 0, 1);
    chk("R9 standby clear", int'(rd_data), 0);
    chk("R8 abort standby", int'(ch_abort), 4'b1010);
    step(0, 0, 3'b000, 1, 0, 0);
    step(0, 1, 3'b000, 0, 0, 0);
    chk("R9 arm dropped", int'(rd_data), 3'b100);
    step(0, 0, 3'b000, 1, 1, 1);
    chk("R9 standby priority", int'(rd_data), 0);

    // R1 reset mid-run
    step(0, 1, 3'b001, 1, 1, 0);
    rst_n = 0; idle();
    chk("R1 reset mid", int'(rd_data), 0);
    rst_n = 1; idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule